// File: doc/BRIEF.md
# Quadrant Shared Packet Buffer

This block is the packet store of a 32-port switch. The storage is split into four quadrant memories. Each quadrant has 1024 rows of 80 bits, two write ports and two read ports. A quadrant is chosen by two bits: whether the source port is in the upper half of the ports (16–31), and whether the destination port is. Code 0 (A) holds traffic from the lower input half to the lower output half. Code 1 (B) holds lower inputs to upper outputs. Code 2 (C) holds upper inputs to lower outputs. Code 3 (D) holds upper inputs to upper outputs.

In each access slot the block serves two write lanes and two read lanes. Write lane *n* always uses write port *n* of the quadrant it addresses, and read lane *n* always uses read port *n*. Each write lane carries a quadrant select that a scheduler computes outside the block, along with the source port, the destination port, a row address and the data. Each read lane carries the requesting output port, the source half of the stored packet and a row address, which come from an outside queue. The unit length in bytes (8 to 10) is a shared input. Bytes of a row past that length read back as zero.

Top module: `quad_packet_buffer`

## Requirements
- R1: A write lane with valid high stores its data in quadrant `wr_quad` at row `wr_row` when `wr_quad` equals {source port bit 4, destination port bit 4}. The codes are A=0, B=1, C=2, D=3.
- R2: A valid write whose `wr_quad` differs from that code stores nothing. Its lane's `wr_err` bit is high in the next cycle. Every other lane and cycle gives `wr_err` low.
- R3: A read lane reads from quadrant {`rd_src_hi`, output port bit 4} at row `rd_row`.
- R4: `rd_vld_o` of a lane equals that lane's `rd_vld` from the previous cycle. The data on `rd_data_o` belongs to that request.
- R5: A read and a write to the same row of the same quadrant in the same cycle return the contents from before the write.
- R6: Both write lanes may store into the same quadrant in one cycle at different rows, and both rows are kept.
- R7: If both write lanes store the same row of the same quadrant in one cycle, the row keeps the data of lane 1.
- R8: Read bytes (byte k in bits 8k+7..8k) at index at or above the effective unit length are zero. The effective length is `unit_bytes` sampled with the read request, limited to the range 8 to 10.
- R9: After a synchronous active-low reset, `rd_vld_o` and `wr_err` are zero.
- R10: The two read lanes may read the same quadrant in the same cycle and each gets its own row.
- R11: Each quadrant has 1024 independent rows. Row 0 and row 1023 hold separate values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_vld | input | 2 | Write request, one bit per lane |
| wr_quad | input | 2x2 | Quadrant select per write lane |
| wr_src_port | input | 2x5 | Source input port per write lane |
| wr_dst_port | input | 2x5 | Destination output port per write lane |
| wr_row | input | 2x10 | Store row per write lane |
| wr_data | input | 2x80 | Row data per write lane |
| wr_err | output | 2 | Rejected write, one cycle after the request |
| rd_vld | input | 2 | Read request per lane |
| rd_src_hi | input | 2 | Source half of the stored packet per read lane |
| rd_out_port | input | 2x5 | Requesting output port per read lane |
| rd_row | input | 2x10 | Read row per lane |
| unit_bytes | input | 4 | Unit length in bytes (8..10) |
| rd_vld_o | output | 2 | Read data valid per lane |
| rd_data_o | output | 2x80 | Masked read data per lane |

## Verification
The clocked checks assume that every request input stays low while reset is asserted. Otherwise a request made in the last reset cycle would have no valid result after release. The bench holds all valids low during reset and changes inputs only at the falling clock edge. It reads only rows it has already written, so no undefined memory content reaches a data comparison. Random unit lengths mostly stay within 8 to 10, and a few directed reads use values outside that range to test the limiting.

// File: rtl/qpb_pkg.sv
// Package: shared quadrant encoding for the quadrant packet buffer.
// Assumes the upper half of the ports is marked by the port number's MSB.
package qpb_pkg;

    typedef enum logic [1:0] {
        QUAD_A = 2'd0,   // low inputs  -> low outputs
        QUAD_B = 2'd1,   // low inputs  -> high outputs
        QUAD_C = 2'd2,   // high inputs -> low outputs
        QUAD_D = 2'd3    // high inputs -> high outputs
    } quad_e;

    // Quadrant that legally holds traffic for a given source/destination half.
    function automatic logic [1:0] home_quad(input logic src_hi, input logic dst_hi);
        return {src_hi, dst_hi};
    endfunction

endpackage

// File: rtl/qpb_steer.sv
// Module: write steering for one write lane.
// Decodes the requested quadrant into a one-hot write enable when it matches
// the home quadrant of the source/destination pair, else raises reject.
// Assumes port numbers are PORT_W bits wide with the MSB selecting the half.
module qpb_steer
    import qpb_pkg::*;
#(
    parameter int PORT_W = 5,
    parameter int NQUAD  = 4
) (
    input  logic              vld,
    input  logic [1:0]        quad,
    input  logic [PORT_W-1:0] src_port,
    input  logic [PORT_W-1:0] dst_port,
    output logic [NQUAD-1:0]  we,
    output logic              reject
);

    logic legal;

    // Decode the quadrant and check it against the port halves.
    always_comb begin
        legal  = (quad == home_quad(src_port[PORT_W-1], dst_port[PORT_W-1]));
        we     = '0;
        reject = vld && !legal;
        if (vld && legal) begin
            we[quad] = 1'b1;
        end
    end

endmodule

// File: rtl/qpb_quad_mem.sv
// Module: one quadrant memory with NWR write ports and NRD read ports.
// Reads are registered (one-cycle latency) and return the pre-write contents
// on a same-row collision. When write ports hit the same row, the highest
// port index wins. Contents are not reset.
module qpb_quad_mem #(
    parameter int DEPTH  = 1024,
    parameter int ROW_W  = 80,
    parameter int NWR    = 2,
    parameter int NRD    = 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic [NWR-1:0]             we,
    input  logic [NWR-1:0][ADDR_W-1:0] waddr,
    input  logic [NWR-1:0][ROW_W-1:0]  wdata,
    input  logic [NRD-1:0]             re,
    input  logic [NRD-1:0][ADDR_W-1:0] raddr,
    output logic [NRD-1:0][ROW_W-1:0]  rdata
);

    logic [ROW_W-1:0] mem [DEPTH];

    // Read ports sample old contents; write ports update in port order.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NRD; r++) begin
            if (re[r]) begin
                rdata[r] <= mem[raddr[r]];
            end
        end
        for (int w = 0; w < NWR; w++) begin
            if (we[w]) begin
                mem[waddr[w]] <= wdata[w];
            end
        end
    end

endmodule

// File: rtl/qpb_rd_mask.sv
// Module: zeroes the bytes of a row past the effective unit length.
// The effective length is the requested length limited to MIN_BYTES..ROW_BYTES.
// Byte k occupies bits 8k+7..8k.
module qpb_rd_mask #(
    parameter int ROW_BYTES = 10,
    parameter int MIN_BYTES = 8,
    parameter int LEN_W     = 4,
    localparam int ROW_W    = ROW_BYTES * 8
) (
    input  logic [ROW_W-1:0] din,
    input  logic [LEN_W-1:0] len,
    output logic [ROW_W-1:0] dout
);

    logic [LEN_W-1:0] eff_len;

    // Limit the requested length to the supported range.
    always_comb begin
        if (len < LEN_W'(MIN_BYTES))      eff_len = LEN_W'(MIN_BYTES);
        else if (len > LEN_W'(ROW_BYTES)) eff_len = LEN_W'(ROW_BYTES);
        else                              eff_len = len;
    end

    for (genvar b = 0; b < ROW_BYTES; b++) begin : g_byte
        // Pass a byte only when it lies inside the effective length.
        assign dout[b*8 +: 8] = (LEN_W'(b) < eff_len) ? din[b*8 +: 8] : 8'h00;
    end

endmodule

// File: rtl/quad_packet_buffer.sv
// Module: top of the quadrant packet buffer.
// Two write lanes and two read lanes per access slot; lane n uses port n of
// each quadrant, so lanes never compete for a port. Writes are steered and
// checked per lane; reads pick the quadrant from the stored packet's source
// half and the requester's output half, with one-cycle latency.
// Assumes request valids are held low while rst_n is low.
module quad_packet_buffer
    import qpb_pkg::*;
#(
    parameter int NUM_PORTS = 32,
    parameter int DEPTH     = 1024,
    parameter int ROW_BYTES = 10,
    parameter int MIN_BYTES = 8,
    parameter int LEN_W     = 4,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int ADDR_W   = $clog2(DEPTH),
    localparam int ROW_W    = ROW_BYTES * 8,
    localparam int NLANE    = 2,
    localparam int NQUAD    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NLANE-1:0]             wr_vld,
    input  logic [NLANE-1:0][1:0]        wr_quad,
    input  logic [NLANE-1:0][PORT_W-1:0] wr_src_port,
    input  logic [NLANE-1:0][PORT_W-1:0] wr_dst_port,
    input  logic [NLANE-1:0][ADDR_W-1:0] wr_row,
    input  logic [NLANE-1:0][ROW_W-1:0]  wr_data,
    output logic [NLANE-1:0]             wr_err,
    input  logic [NLANE-1:0]             rd_vld,
    input  logic [NLANE-1:0]             rd_src_hi,
    input  logic [NLANE-1:0][PORT_W-1:0] rd_out_port,
    input  logic [NLANE-1:0][ADDR_W-1:0] rd_row,
    input  logic [LEN_W-1:0]             unit_bytes,
    output logic [NLANE-1:0]             rd_vld_o,
    output logic [NLANE-1:0][ROW_W-1:0]  rd_data_o
);

    logic [NLANE-1:0][NQUAD-1:0]            lane_we;
    logic [NLANE-1:0]                       lane_rej;
    logic [NLANE-1:0][1:0]                  rd_quad;
    logic [NLANE-1:0][1:0]                  rd_quad_q;
    logic [LEN_W-1:0]                       len_q;
    logic [NQUAD-1:0][NLANE-1:0][ROW_W-1:0] quad_rdata;

    // ---------------- write steering ----------------
    for (genvar l = 0; l < NLANE; l++) begin : g_wlane
        qpb_steer #(.PORT_W(PORT_W), .NQUAD(NQUAD)) u_steer (
            .vld      (wr_vld[l]),
            .quad     (wr_quad[l]),
            .src_port (wr_src_port[l]),
            .dst_port (wr_dst_port[l]),
            .we       (lane_we[l]),
            .reject   (lane_rej[l])
        );
    end

    // ---------------- read quadrant select ----------------
    for (genvar r = 0; r < NLANE; r++) begin : g_rsel
        assign rd_quad[r] = home_quad(rd_src_hi[r], rd_out_port[r][PORT_W-1]);
    end

    // ---------------- quadrant memories ----------------
    for (genvar q = 0; q < NQUAD; q++) begin : g_quad
        logic [NLANE-1:0] q_we;
        logic [NLANE-1:0] q_re;
        for (genvar p = 0; p < NLANE; p++) begin : g_port
            assign q_we[p] = lane_we[p][q];
            assign q_re[p] = rd_vld[p] && (rd_quad[p] == 2'(q));
        end
        qpb_quad_mem #(.DEPTH(DEPTH), .ROW_W(ROW_W), .NWR(NLANE), .NRD(NLANE)) u_mem (
            .clk   (clk),
            .we    (q_we),
            .waddr (wr_row),
            .wdata (wr_data),
            .re    (q_re),
            .raddr (rd_row),
            .rdata (quad_rdata[q])
        );
    end

    // Register read valid, read quadrant, length and write errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld_o  <= '0;
            rd_quad_q <= '0;
            len_q     <= LEN_W'(MIN_BYTES);
            wr_err    <= '0;
        end else begin
            rd_vld_o  <= rd_vld;
            rd_quad_q <= rd_quad;
            len_q     <= unit_bytes;
            wr_err    <= lane_rej;
        end
    end

    // ---------------- output select and byte mask ----------------
    for (genvar r = 0; r < NLANE; r++) begin : g_rout
        qpb_rd_mask #(.ROW_BYTES(ROW_BYTES), .MIN_BYTES(MIN_BYTES), .LEN_W(LEN_W)) u_mask (
            .din  (quad_rdata[rd_quad_q[r]][r]),
            .len  (len_q),
            .dout (rd_data_o[r])
        );

        // R4: a request yields valid data exactly one cycle later
        assert_rd_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
            rd_vld[r] |=> rd_vld_o[r]);
        assert_rd_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_vld[r] |=> !rd_vld_o[r]);
        // R8: with a unit of at most MIN_BYTES, the upper bytes read as zero
        assert_short_unit_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_vld_o[r] && ($past(unit_bytes) <= LEN_W'(MIN_BYTES)))
            |-> (rd_data_o[r][ROW_W-1:MIN_BYTES*8] == '0));
    end

    for (genvar l = 0; l < NLANE; l++) begin : g_werr_chk
        // R2: an error flag is only ever the echo of a request
        assert_err_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_vld[l] |=> !wr_err[l]);
        // R1: a legal quadrant select never produces an error
        assert_legal_no_err_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_vld[l] && (wr_quad[l] == {wr_src_port[l][PORT_W-1], wr_dst_port[l][PORT_W-1]}))
            |=> !wr_err[l]);
    end

endmodule

// File: tb/quad_packet_buffer_tb.sv
`timescale 1ns/1ps
module quad_packet_buffer_tb;

    localparam int ROW_W = 80;
    localparam int DEPTH = 1024;
    localparam int AW    = 10;
    localparam int PW    = 5;

    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic                 rst_n;
    logic [1:0]           wr_vld;
    logic [1:0][1:0]      wr_quad;
    logic [1:0][PW-1:0]   wr_src_port, wr_dst_port;
    logic [1:0][AW-1:0]   wr_row;
    logic [1:0][ROW_W-1:0] wr_data;
    logic [1:0]           wr_err;
    logic [1:0]           rd_vld, rd_src_hi;
    logic [1:0][PW-1:0]   rd_out_port;
    logic [1:0][AW-1:0]   rd_row;
    logic [3:0]           unit_bytes;
    logic [1:0]           rd_vld_o;
    logic [1:0][ROW_W-1:0] rd_data_o;

    quad_packet_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_vld(wr_vld), .wr_quad(wr_quad), .wr_src_port(wr_src_port),
        .wr_dst_port(wr_dst_port), .wr_row(wr_row), .wr_data(wr_data),
        .wr_err(wr_err),
        .rd_vld(rd_vld), .rd_src_hi(rd_src_hi), .rd_out_port(rd_out_port),
        .rd_row(rd_row), .unit_bytes(unit_bytes),
        .rd_vld_o(rd_vld_o), .rd_data_o(rd_data_o)
    );

    logic [ROW_W-1:0] ref_mem [4][DEPTH];
    int    n_vec = 0;
    int    n_bad = 0;
    string rd_tag [2];

    function automatic logic [ROW_W-1:0] mask_exp(input logic [ROW_W-1:0] d, input logic [3:0] len);
        int eff;
        logic [ROW_W-1:0] o;
        eff = (len < 8) ? 8 : ((len > 10) ? 10 : int'(len));
        o = d;
        for (int b = 0; b < 10; b++) if (b >= eff) o[b*8 +: 8] = 8'h00;
        return o;
    endfunction

    function automatic logic [79:0] rnd80();
        return {16'($urandom), $urandom, $urandom};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [ROW_W-1:0] act, input logic [ROW_W-1:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        wr_vld = '0; rd_vld = '0;
        rd_tag[0] = "R3"; rd_tag[1] = "R3";
    endtask

    task automatic wr(input int l, input logic [1:0] q, input int src, input int dst,
                      input int row, input logic [ROW_W-1:0] d);
        wr_vld[l] = 1'b1; wr_quad[l] = q;
        wr_src_port[l] = PW'(src); wr_dst_port[l] = PW'(dst);
        wr_row[l] = AW'(row); wr_data[l] = d;
    endtask

    task automatic rd(input int r, input logic src_hi, input int outp, input int row, input string tag);
        rd_vld[r] = 1'b1; rd_src_hi[r] = src_hi;
        rd_out_port[r] = PW'(outp); rd_row[r] = AW'(row); rd_tag[r] = tag;
    endtask

    // Apply the inputs set so far for one clock, then check all outputs.
    task automatic step();
        logic             e_rv  [2];
        logic             e_err [2];
        logic [ROW_W-1:0] e_rd  [2];
        string            tg    [2];
        for (int r = 0; r < 2; r++) begin
            e_rv[r] = rd_vld[r];
            tg[r]   = rd_tag[r];
            e_rd[r] = mask_exp(ref_mem[{rd_src_hi[r], rd_out_port[r][PW-1]}][rd_row[r]], unit_bytes);
        end
        for (int l = 0; l < 2; l++) begin
            logic ok;
            ok = (wr_quad[l] == {wr_src_port[l][PW-1], wr_dst_port[l][PW-1]});
            e_err[l] = wr_vld[l] && !ok;
            if (wr_vld[l] && ok) ref_mem[wr_quad[l]][wr_row[l]] = wr_data[l];
        end
        @(negedge clk);
        for (int l = 0; l < 2; l++)
            check(wr_err[l] == e_err[l], "R2", $sformatf("wr_err lane %0d", l),
                  ROW_W'(wr_err[l]), ROW_W'(e_err[l]));
        for (int r = 0; r < 2; r++) begin
            check(rd_vld_o[r] == e_rv[r], "R4", $sformatf("rd_vld_o lane %0d", r),
                  ROW_W'(rd_vld_o[r]), ROW_W'(e_rv[r]));
            if (e_rv[r])
                check(rd_data_o[r] === e_rd[r], tg[r], $sformatf("rd_data lane %0d", r),
                      rd_data_o[r], e_rd[r]);
        end
        idle();
    endtask

    function automatic int pick_row();
        int k;
        k = $urandom % 32;
        return (k < 16) ? k : (DEPTH - 32 + k);
    endfunction

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; unit_bytes = 4'd10;
        wr_quad = '0; wr_src_port = '0; wr_dst_port = '0; wr_row = '0; wr_data = '0;
        rd_src_hi = '0; rd_out_port = '0; rd_row = '0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: outputs clear after reset
        check(rd_vld_o == 2'b00, "R9", "rd_vld_o after reset", ROW_W'(rd_vld_o), '0);
        check(wr_err == 2'b00, "R9", "wr_err after reset", ROW_W'(wr_err), '0);

        // Prefill rows 0..15 and 1008..1023 of every quadrant (R1 legal writes).
        for (int q = 0; q < 4; q++)
            for (int k = 0; k < 32; k += 2) begin
                int ra, rb;
                ra = (k < 16) ? k : DEPTH - 32 + k;
                rb = ra + 1;
                wr(0, 2'(q), q[1] ? 20 : 3, q[0] ? 30 : 7, ra, rnd80());
                wr(1, 2'(q), q[1] ? 17 : 0, q[0] ? 16 : 15, rb, rnd80());
                step();
            end

        // R1: same row index in all four quadrants, distinct data, read back each.
        wr(0, 2'd0, 1, 2, 9, 80'hA0A0_0000_0000_0000_0001);
        wr(1, 2'd1, 5, 20, 9, 80'hB0B0_0000_0000_0000_0002);
        step();
        wr(0, 2'd2, 18, 4, 9, 80'hC0C0_0000_0000_0000_0003);
        wr(1, 2'd3, 31, 31, 9, 80'hD0D0_0000_0000_0000_0004);
        step();
        rd(0, 1'b0, 3, 9, "R1"); rd(1, 1'b0, 25, 9, "R1"); step();
        rd(0, 1'b1, 12, 9, "R1"); rd(1, 1'b1, 16, 9, "R1"); step();

        // R2: illegal select (quad A with source 20) is rejected, row unchanged.
        wr(0, 2'd0, 20, 2, 9, 80'hDEAD_DEAD_DEAD_DEAD_DEAD);
        wr(1, 2'd3, 2, 30, 9, 80'hBEEF_BEEF_BEEF_BEEF_BEEF);
        step();
        rd(0, 1'b0, 0, 9, "R2"); rd(1, 1'b1, 31, 9, "R2"); step();

        // R5: read and write of the same row in one cycle returns old data.
        wr(0, 2'd1, 4, 19, 3, 80'h1111_2222_3333_4444_5555);
        rd(0, 1'b0, 19, 3, "R5");
        step();
        rd(0, 1'b0, 19, 3, "R5"); step();

        // R6: both lanes into quadrant C, different rows.
        wr(0, 2'd2, 16, 1, 4, 80'h6666_0000_0000_0000_0006);
        wr(1, 2'd2, 29, 14, 5, 80'h6666_0000_0000_0000_0007);
        step();
        rd(0, 1'b1, 1, 4, "R6"); rd(1, 1'b1, 2, 5, "R6"); step();

        // R7: both lanes same row of quadrant A; lane 1 wins.
        wr(0, 2'd0, 6, 6, 7, 80'h7777_0000_0000_0000_0000);
        wr(1, 2'd0, 8, 8, 7, 80'h7777_1111_1111_1111_1111);
        step();
        rd(1, 1'b0, 0, 7, "R7"); step();
        check(rd_data_o[1] == 80'h7777_1111_1111_1111_1111, "R7", "lane 1 wins",
              rd_data_o[1], 80'h7777_1111_1111_1111_1111);

        // R10 / R11: both read lanes on quadrant D, rows 0 and 1023.
        wr(0, 2'd3, 16, 16, 0, 80'h0000_0000_0000_0000_00AA);
        wr(1, 2'd3, 17, 17, 1023, 80'hFFFF_0000_0000_0000_00BB);
        step();
        rd(0, 1'b1, 20, 0, "R10"); rd(1, 1'b1, 21, 1023, "R11"); step();

        // R8: unit length masking, including out-of-range lengths.
        for (int i = 0; i < 6; i++) begin
            logic [3:0] lens [6] = '{4'd8, 4'd9, 4'd10, 4'd0, 4'd15, 4'd3};
            unit_bytes = lens[i];
            rd(0, 1'b0, 30, 2, "R8"); rd(1, 1'b1, 2, 1020, "R8");
            step();
        end
        unit_bytes = 4'd10;

        // Random mixed traffic.
        for (int n = 0; n < 600; n++) begin
            for (int l = 0; l < 2; l++)
                if ($urandom % 2) begin
                    int s, d;
                    logic [1:0] q;
                    s = $urandom % 32; d = $urandom % 32;
                    q = (($urandom % 8) == 0) ? 2'($urandom) : {s[4], d[4]};
                    wr(l, q, s, d, pick_row(), rnd80());
                end
            for (int r = 0; r < 2; r++)
                if ($urandom % 2) rd(r, 1'($urandom), $urandom % 32, pick_row(), "R3");
            unit_bytes = 4'(8 + ($urandom % 3));
            step();
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule